// File: doc/BRIEF.md
# Split-Width IOMMU Control and Base Register Bank

This block holds the two 64-bit configuration words that a DMA address translator needs. The first is a control word, whose bit 0 enables translation. The second is the base address of the translation table in memory. A simple strobe-based bus port reaches both words, and that port can move either a whole 64-bit word or one 32-bit half. Both words are also driven continuously at full width to the translation logic next to this block.

Halves are laid out big-endian. A 32-bit access at a register's own offset selects its upper half, and a 32-bit access four bytes higher selects its lower half. A pair of flush offsets is decoded but has no storage. Every other offset in the window is empty.

Reads are registered: read data appears the cycle after the read strobe and holds until the next read. Reset clears both words, so translation starts disabled.

Top module: `iommu_regbank`

## Requirements
- R1: After reset, the control word, the base word and the read data are all zero.
- R2: A 64-bit write (`wide`=1) at offset 0x00 replaces the whole control word, and one at offset 0x08 replaces the whole base word.
- R3: A 32-bit write (`wide`=0) at 0x00 (control) or 0x08 (base) loads `wdata[31:0]` into bits 63:32 and keeps bits 31:0.
- R4: A write of either size at 0x04 (control) or 0x0C (base) loads `wdata[31:0]` into bits 31:0 and keeps bits 63:32.
- R5: A 64-bit read at 0x00 or 0x08 returns the whole register.
- R6: A 32-bit read at 0x00 or 0x08 returns bits 63:32 in `rdata[31:0]`, with `rdata[63:32]` zero.
- R7: A read of either size at 0x04 or 0x0C returns bits 31:0 in `rdata[31:0]`, with `rdata[63:32]` zero.
- R8: Reads of the flush offsets 0x10 and 0x14 return zero, and writes to them change neither register.
- R9: Reads of any other offset return zero, and writes to one change neither register.
- R10: `rdata` is valid on the cycle after `rd_en` and holds its value while `rd_en` is low.
- R11: A read and a write to the same register in the same cycle return the value the register had before the write.
- R12: `ctrl_q` and `base_q` show the full register values and change on the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| addr | input | ADDR_W (8) | Byte offset within the bank |
| wdata | input | 64 | Write data; a 32-bit write uses bits 31:0 |
| rdata | output | 64 | Registered read data |
| ctrl_q | output | 64 | Current control word |
| base_q | output | 64 | Current table base word |

## Verification
A half-select decoded the wrong way round, or a write that reaches the wrong register, shows on `ctrl_q` or `base_q` at the edge that takes the write. The same fault shows in `rdata` one cycle after the next read of that offset. A decode that reaches into the flush or empty offsets disturbs a stored word on the very write that hits those offsets. Because both words are on ports, none of these faults can stay hidden for more than a single cycle.

// File: rtl/iommu_regbank.sv
module iommu_regbank #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] base_q
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [ADDR_W-1:0] OFF_CTRL_HI = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFF_CTRL_LO = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFF_BASE_HI = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] OFF_BASE_LO = ADDR_W'('h0C);

  logic hit_ch, hit_cl, hit_bh, hit_bl;
  assign hit_ch = (addr == OFF_CTRL_HI);
  assign hit_cl = (addr == OFF_CTRL_LO);
  assign hit_bh = (addr == OFF_BASE_HI);
  assign hit_bl = (addr == OFF_BASE_LO);

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] cur,
                                              input logic [DATA_W-1:0] d,
                                              input logic hi, input logic lo,
                                              input logic w64);
    logic [DATA_W-1:0] r;
    r = cur;
    if (hi && w64)  r = d;
    else if (hi)    r[DATA_W-1:HALF_W] = d[HALF_W-1:0];
    else if (lo)    r[HALF_W-1:0] = d[HALF_W-1:0];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      base_q <= '0;
    end else if (wr_en) begin
      ctrl_q <= merge(ctrl_q, wdata, hit_ch, hit_cl, wide);
      base_q <= merge(base_q, wdata, hit_bh, hit_bl, wide);
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_ch)      rd_mux = wide ? ctrl_q : {{HALF_W{1'b0}}, ctrl_q[DATA_W-1:HALF_W]};
    else if (hit_cl) rd_mux = {{HALF_W{1'b0}}, ctrl_q[HALF_W-1:0]};
    else if (hit_bh) rd_mux = wide ? base_q : {{HALF_W{1'b0}}, base_q[DATA_W-1:HALF_W]};
    else if (hit_bl) rd_mux = {{HALF_W{1'b0}}, base_q[HALF_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

module iommu_regbank_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic              wide,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] base_q
);
  localparam int HALF_W = DATA_W / 2;
  logic ctrl_sel, base_sel, mapped;
  assign ctrl_sel = (addr == ADDR_W'('h00)) || (addr == ADDR_W'('h04));
  assign base_sel = (addr == ADDR_W'('h08)) || (addr == ADDR_W'('h0C));
  assign mapped   = ctrl_sel || base_sel;

  p_hi_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wide && addr == ADDR_W'('h00)) |=>
      (ctrl_q[DATA_W-1:HALF_W] == $past(wdata[HALF_W-1:0]) &&
       ctrl_q[HALF_W-1:0] == $past(ctrl_q[HALF_W-1:0])));

  p_lo_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'('h0C)) |=>
      (base_q[HALF_W-1:0] == $past(wdata[HALF_W-1:0]) &&
       base_q[DATA_W-1:HALF_W] == $past(base_q[DATA_W-1:HALF_W])));

  p_full_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wide && addr == ADDR_W'('h08)) |=> (base_q == $past(wdata)));

  p_untouched_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && mapped) |=> ($stable(ctrl_q) && $stable(base_q)));

  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped) |=> (rdata == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  p_old_value_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'('h04)) |=>
      (rdata == {{HALF_W{1'b0}}, $past(ctrl_q[HALF_W-1:0])}));
endmodule

bind iommu_regbank iommu_regbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wide(wide),
  .addr(addr), .wdata(wdata), .rdata(rdata), .ctrl_q(ctrl_q), .base_q(base_q));

// File: tb/test_iommu_regbank.sv
module test_iommu_regbank;
  localparam int AW = 8;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, wide = 0;
  logic [AW-1:0] addr = '0;
  logic [63:0] wdata = '0, rdata, ctrl_q, base_q;
  logic [63:0] m_ctrl = '0, m_base = '0;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  iommu_regbank #(.ADDR_W(AW)) i_iommu_regbank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wide(wide),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ctrl_q(ctrl_q), .base_q(base_q));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_write(input int a, input bit w, input logic [63:0] d);
    case (a)
      'h00: if (w) m_ctrl = d; else m_ctrl[63:32] = d[31:0];
      'h04: m_ctrl[31:0] = d[31:0];
      'h08: if (w) m_base = d; else m_base[63:32] = d[31:0];
      'h0C: m_base[31:0] = d[31:0];
      default: ;
    endcase
  endtask

  function automatic logic [63:0] model_read(input int a, input bit w);
    case (a)
      'h00: return w ? m_ctrl : {32'h0, m_ctrl[63:32]};
      'h04: return {32'h0, m_ctrl[31:0]};
      'h08: return w ? m_base : {32'h0, m_base[63:32]};
      'h0C: return {32'h0, m_base[31:0]};
      default: return 64'h0;
    endcase
  endfunction

  function automatic string tag(input int a, input bit w, input bit rd);
    if (a == 'h00 || a == 'h08) return rd ? (w ? "R5" : "R6") : (w ? "R2 R12" : "R3 R12");
    if (a == 'h04 || a == 'h0C) return rd ? "R7" : "R4 R12";
    if (a == 'h10 || a == 'h14) return "R8";
    return "R9";
  endfunction

  task automatic bus_write(input int a, input bit w, input logic [63:0] d);
    @(negedge clk); wr_en = 1; wide = w; addr = AW'(a); wdata = d;
    @(negedge clk); wr_en = 0;
    model_write(a, w, d);
  endtask

  task automatic bus_read(input int a, input bit w);
    @(negedge clk); rd_en = 1; wide = w; addr = AW'(a);
    @(negedge clk); rd_en = 0;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] d, held;
    repeat (3) @(negedge clk);
    check("R1 ctrl", ctrl_q, 64'h0);
    check("R1 base", base_q, 64'h0);
    check("R1 rdata", rdata, 64'h0);
    rst_n = 1;

    for (int a = 0; a < (1 << AW); a++) begin
      for (int w = 0; w < 2; w++) begin
        d = 64'hF0E1D2C3B4A59687 ^ (64'(a) * 64'h0001020304050607) ^
            (w != 0 ? 64'hFFFF0000FFFF0000 : 64'h0);
        bus_write(a, w[0], d);
        check({tag(a, w[0], 0), " ctrl"}, ctrl_q, m_ctrl);
        check({tag(a, w[0], 0), " base"}, base_q, m_base);
        bus_read(a, w[0]);
        check(tag(a, w[0], 1), rdata, model_read(a, w[0]));
      end
    end

    for (int a = 0; a < 16; a += 4) begin
      bus_read(a, 1'b0);
      check(tag(a, 1'b0, 1), rdata, model_read(a, 1'b0));
      bus_read(a, 1'b1);
      check(tag(a, 1'b1, 1), rdata, model_read(a, 1'b1));
    end

    bus_write('h00, 1'b1, 64'h1111_2222_3333_4444);
    bus_read('h00, 1'b1);
    held = rdata;
    check("R5", held, 64'h1111_2222_3333_4444);
    bus_write('h00, 1'b1, 64'hDEAD_BEEF_0000_0001);
    repeat (3) @(negedge clk);
    check("R10 hold", rdata, held);
    check("R12 ctrl", ctrl_q, 64'hDEAD_BEEF_0000_0001);

    @(negedge clk); wr_en = 1; rd_en = 1; wide = 0; addr = AW'('h04); wdata = 64'h0000_0000_5555_AAAA;
    @(negedge clk); wr_en = 0; rd_en = 0;
    model_write('h04, 1'b0, 64'h0000_0000_5555_AAAA);
    check("R11 old value", rdata, 64'h0000_0000_0000_0001);
    check("R11 new ctrl", ctrl_q, m_ctrl);
    bus_read('h04, 1'b0);
    check("R7 after R11", rdata, 64'h0000_0000_5555_AAAA);

    bus_write('h10, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_write('h14, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R8 ctrl", ctrl_q, m_ctrl);
    check("R8 base", base_q, m_base);

    rst_n = 0;
    @(negedge clk);
    check("R1 ctrl again", ctrl_q, 64'h0);
    check("R1 base again", base_q, 64'h0);
    check("R1 rdata again", rdata, 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule